// File: doc/BRIEF.md
# Ring Cellular Automaton Pattern Generator

This block produces a pseudo-random word from a one-dimensional binary cellular automaton. The cells are closed into a ring, and each step updates all of them in the same clock edge. A cell's next value depends on three bits: the cell itself and the cells on either side of it. An 8-bit rule register turns that 3-bit neighbourhood into the new value. Any of the 256 elementary rules can be selected, and the rule can be changed while the block runs.

The host writes a starting pattern through the seed port and a rule through the rule port. Each of these takes effect after a single-cycle load strobe. The host then pulses the step request once for each new generation it wants. The full cell array appears on the pattern output at all times. The cell count is a parameter, as is the rule that reset selects. Another parameter chooses how each cell's rule lookup is built.

Top module: `ca_ring_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pattern register clears to all zeros and the rule register takes the value 30 (8'h1E).
- R2: When `seed_load` is high at an edge, `pattern` equals the `seed` value from that cycle after the edge.
- R3: When `step` is high and `seed_load` is low, every cell i becomes bit k of the rule register, where k = {cell i-1, cell i, cell i+1}. Cell i-1 is the MSB (bit 2) and cell i+1 is the LSB (bit 0). As examples, rule 8'hF0 moves each bit from index i to index i+1, and rule 8'hAA moves each bit from index i+1 to index i.
- R4: The array is a ring. The neighbour at i-1 of cell 0 is cell CELLS-1, and the neighbour at i+1 of cell CELLS-1 is cell 0. Under rule 30, a single 1 at bit 0 produces 32'h80000003, and a single 1 at bit 31 produces 32'hC0000001.
- R5: When `seed_load` and `step` are high in the same cycle, the seed is loaded and no generation step takes place.
- R6: When neither `seed_load` nor `step` is high, `pattern` keeps its value.
- R7: A high `rule_load` copies `rule` into the rule register. The pattern does not change unless a strobe acts on it. A `step` in the same cycle as the rule load still uses the previous rule. The new rule first applies to the next `step` after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seed | input | CELLS | Starting pattern to load |
| seed_load | input | 1 | Single-cycle strobe that loads `seed` |
| rule | input | 8 | Update rule to load |
| rule_load | input | 1 | Single-cycle strobe that loads `rule` |
| step | input | 1 | Request for one new generation |
| pattern | output | CELLS | Current cell array |

## Verification
The in-RTL properties check on every cycle that:
- reset clears the state and restores the default rule;
- a seed load always lands;
- a load wins over a step;
- an idle cycle holds the pattern;
- the rule register changes only on its strobe;
- each step's result matches the next-generation word computed from the previous cycle's state and rule.

Some behaviours only the bench scenarios can show. These are the neighbour bit ordering, the wrap-around at both ends, and the exact values of known generations. Also among them is the one-cycle delay before a newly loaded rule takes effect. These cases are pinned down by directed seeds under rules 30, F0 and AA. Long random runs then cover mixed strobes against a reference model.

// File: rtl/ca_ring_pkg.sv
package ca_ring_pkg;

   localparam int unsigned NBHD_W = 3;
   localparam int unsigned RULE_W = 1 << NBHD_W;

   typedef logic [RULE_W-1:0] rule_t;

   localparam rule_t RULE_DEFAULT = 8'h1E;

   // Rule lookup: neighbourhood index {left, centre, right}, left is MSB.
   function automatic logic rule_pick(rule_t r, logic lt, logic ct, logic rt);
      logic [NBHD_W-1:0] idx;
      idx = {lt, ct, rt};
      return r[idx];
   endfunction

endpackage

// File: rtl/ca_ring_cell.sv
module ca_ring_cell
   import ca_ring_pkg::*;
#(
   parameter int unsigned LOOKUP_STYLE = 0   // 0: indexed mux, 1: decoded minterms
) (
   input  logic  nb_left,
   input  logic  nb_centre,
   input  logic  nb_right,
   input  rule_t rule_q,
   output logic  cell_next
);

   generate
      if (LOOKUP_STYLE == 0) begin : g_mux
         always_comb cell_next = rule_pick(rule_q, nb_left, nb_centre, nb_right);
      end else if (LOOKUP_STYLE == 1) begin : g_sop
         logic [RULE_W-1:0] minterm;
         logic [NBHD_W-1:0] nb_idx;
         always_comb begin
            nb_idx = {nb_left, nb_centre, nb_right};
            for (int k = 0; k < RULE_W; k++) begin
               minterm[k] = (nb_idx == NBHD_W'(k)) & rule_q[k];
            end
            cell_next = |minterm;
         end
      end else begin : g_bad_style
         $error("ca_ring_cell: LOOKUP_STYLE must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/ca_ring_next.sv
module ca_ring_next
   import ca_ring_pkg::*;
#(
   parameter int unsigned CELLS        = 32,
   parameter int unsigned LOOKUP_STYLE = 0
) (
   input  logic [CELLS-1:0] cur_state,
   input  rule_t            rule_q,
   output logic [CELLS-1:0] next_state
);

   localparam int unsigned LAST = CELLS - 1;

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_cell
         localparam int unsigned IDX_L = (i == 0)    ? LAST : i - 1;
         localparam int unsigned IDX_R = (i == LAST) ? 0    : i + 1;
         ca_ring_cell #(
            .LOOKUP_STYLE (LOOKUP_STYLE)
         ) u_cell (
            .nb_left   (cur_state[IDX_L]),
            .nb_centre (cur_state[i]),
            .nb_right  (cur_state[IDX_R]),
            .rule_q    (rule_q),
            .cell_next (next_state[i])
         );
      end
   endgenerate

endmodule

// File: rtl/ca_ring_rule.sv
module ca_ring_rule
   import ca_ring_pkg::*;
#(
   parameter rule_t RESET_RULE = RULE_DEFAULT
) (
   input  logic  clk,
   input  logic  rst_n,
   input  rule_t rule_in,
   input  logic  rule_ld,
   output rule_t rule_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       rule_q <= RESET_RULE;
      else if (rule_ld) rule_q <= rule_in;
   end

   // R7: rule register follows its strobe only
   p_rule_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rule_ld |=> rule_q == $past(rule_in));
   p_rule_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rule_ld |=> $stable(rule_q));
   // R1: reset value of the rule
   p_rule_reset_r1: assert property (@(posedge clk)
      !rst_n |=> rule_q == RESET_RULE);

endmodule

// File: rtl/ca_ring_state.sv
module ca_ring_state #(
   parameter int unsigned CELLS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CELLS-1:0] seed_in,
   input  logic             seed_ld,
   input  logic             adv,
   input  logic [CELLS-1:0] gen_next,
   output logic [CELLS-1:0] state_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= '0;
      else if (seed_ld) state_q <= seed_in;
      else if (adv)     state_q <= gen_next;
   end

   // R2: a seed load always lands
   p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_ld |=> state_q == $past(seed_in));
   // R5: load beats step
   p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_ld && adv) |=> state_q == $past(seed_in));
   // R6: idle cycle holds
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_ld && !adv) |=> $stable(state_q));
   // R1: reset clears the cells
   p_state_reset_r1: assert property (@(posedge clk)
      !rst_n |=> state_q == '0);

endmodule

// File: rtl/ca_ring_gen.sv
module ca_ring_gen
   import ca_ring_pkg::*;
#(
   parameter int unsigned CELLS        = 32,
   parameter rule_t       RESET_RULE   = RULE_DEFAULT,
   parameter int unsigned LOOKUP_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CELLS-1:0] seed,
   input  logic             seed_load,
   input  logic [7:0]       rule,
   input  logic             rule_load,
   input  logic             step,
   output logic [CELLS-1:0] pattern
);

   generate
      if (CELLS < NBHD_W) begin : g_bad_cells
         $error("ca_ring_gen: CELLS must be at least 3");
      end
      if (LOOKUP_STYLE > 1) begin : g_bad_lookup
         $error("ca_ring_gen: LOOKUP_STYLE must be 0 or 1");
      end
   endgenerate

   rule_t            rule_q;
   logic [CELLS-1:0] state_q;
   logic [CELLS-1:0] gen_next;

   ca_ring_rule #(
      .RESET_RULE (RESET_RULE)
   ) u_rule (
      .clk     (clk),
      .rst_n   (rst_n),
      .rule_in (rule),
      .rule_ld (rule_load),
      .rule_q  (rule_q)
   );

   ca_ring_next #(
      .CELLS        (CELLS),
      .LOOKUP_STYLE (LOOKUP_STYLE)
   ) u_next (
      .cur_state  (state_q),
      .rule_q     (rule_q),
      .next_state (gen_next)
   );

   ca_ring_state #(
      .CELLS (CELLS)
   ) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_in  (seed),
      .seed_ld  (seed_load),
      .adv      (step),
      .gen_next (gen_next),
      .state_q  (state_q)
   );

   assign pattern = state_q;

   // R3: a step without load yields the generation computed from last cycle's state and rule
   p_step_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !seed_load) |=> pattern == $past(gen_next));

endmodule

// File: tb/test_ca_ring_gen.sv
module test_ca_ring_gen;

   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] seed;
   logic         seed_load;
   logic [7:0]   rule;
   logic         rule_load;
   logic         step;
   logic [N-1:0] pattern;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [N-1:0] m_state;
   logic [7:0]   m_rule;

   always #4 clk = ~clk;   // 125 MHz

   ca_ring_gen #(.CELLS(N)) i_ca_ring_gen (
      .clk(clk), .rst_n(rst_n), .seed(seed), .seed_load(seed_load),
      .rule(rule), .rule_load(rule_load), .step(step), .pattern(pattern)
   );

   function automatic logic [N-1:0] gen_model(logic [N-1:0] s, logic [7:0] r);
      logic [N-1:0] o;
      for (int i = 0; i < N; i++) begin
         logic l, c, rr;
         l  = s[(i + N - 1) % N];
         c  = s[i];
         rr = s[(i + 1) % N];
         o[i] = r[{l, c, rr}];
      end
      return o;
   endfunction

   task automatic check(input logic [N-1:0] exp, input string req);
      n_vec++;
      if (pattern !== exp) begin
         n_fail++;
         $display("FAIL %s: pattern=%h expected=%h", req, pattern, exp);
      end
   endtask

   // Drive one cycle at the falling edge, advance the model, compare after the rising edge.
   task automatic cyc(input logic [N-1:0] sd, input logic sl, input logic [7:0] rl,
                      input logic rld, input logic st, input string req);
      @(negedge clk);
      seed = sd; seed_load = sl; rule = rl; rule_load = rld; step = st;
      @(posedge clk);
      if (sl)      m_state = sd;
      else if (st) m_state = gen_model(m_state, m_rule);
      if (rld)     m_rule = rl;
      #2;
      check(m_state, req);
   endtask

   task automatic idle(input string req);
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b0, req);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; seed = '1; seed_load = 1'b1; rule = 8'hFF; rule_load = 1'b1; step = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1; seed_load = 1'b0; rule_load = 1'b0; step = 1'b0;
      m_state = '0; m_rule = 8'h1E;
      // R1: reset state is zero
      #1; check('0, "R1 reset pattern");

      // R1/R4: default rule 30 from a single bit at 0 wraps both ways
      cyc(32'h1, 1'b1, 8'h00, 1'b0, 1'b0, "R2 seed load");
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R4 wrap low");
      check(32'h80000003, "R4 wrap low golden");
      cyc(32'h80000000, 1'b1, 8'h00, 1'b0, 1'b0, "R2 seed high bit");
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R4 wrap high");
      check(32'hC0000001, "R4 wrap high golden");
      cyc(32'h00010000, 1'b1, 8'h00, 1'b0, 1'b0, "R2 seed mid");
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R3 rule30 gen1");
      check(32'h00038000, "R1 default rule30 gen1");
      for (int g = 0; g < 40; g++) cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R3 rule30 generations");

      // R6: idle cycles hold
      for (int k = 0; k < 4; k++) idle("R6 hold");

      // R3: neighbour ordering via rule F0 (left copy) and AA (right copy)
      cyc(32'h80000001, 1'b1, 8'hF0, 1'b1, 1'b0, "R7 rule load no pattern change");
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R3 rule F0 step");
      check(32'h00000003, "R3 rule F0 moves up with wrap");
      cyc('0, 1'b0, 8'hAA, 1'b1, 1'b1, "R7 same-cycle step uses old rule");
      check(32'h00000006, "R7 old rule F0 applied");
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R7 new rule AA first step");
      check(32'h00000003, "R3 rule AA moves down");
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R4 rule AA wrap");
      check(32'h80000001, "R4 rule AA wrap golden");

      // R5: load beats step
      cyc(32'hDEADBEEF, 1'b1, 8'h00, 1'b0, 1'b1, "R5 load priority");
      check(32'hDEADBEEF, "R5 load priority golden");

      // R7: rule load alone leaves pattern untouched
      cyc('0, 1'b0, 8'h5A, 1'b1, 1'b0, "R7 rule load only");
      check(32'hDEADBEEF, "R7 pattern unchanged");

      // Constrained random mix
      for (int t = 0; t < 3000; t++) begin
         logic [31:0] r;
         r = $urandom;
         cyc($urandom, (r[3:0] == 4'd0), r[15:8], (r[7:5] == 3'd0), (r[17:16] != 2'd0),
             "R3 random mix");
      end

      // Mid-run reset: R1
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      m_state = '0; m_rule = 8'h1E;
      check('0, "R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      cyc(32'h1, 1'b1, 8'h00, 1'b0, 1'b0, "R2 seed after reset");
      cyc('0, 1'b0, 8'h00, 1'b0, 1'b1, "R1 rule30 restored");
      check(32'h80000003, "R1 rule30 restored golden");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule